// File: doc/BRIEF.md
# Streaming Two-Way Sorted Merge Unit

The unit combines two ascending lists of unsigned words, each held in a memory with a one-cycle registered read, into one ascending list. It writes that list to a destination memory. A start pulse latches the two list lengths. The unit then keeps one head element from each source and sends the smaller head to the write port. In the same cycle it requests the next word of the source it drew from. The result is one stored word per clock from the first store to the last. Once one source runs out, the rest of the other source is passed straight through at the same rate.

Each source is read through its own address port. The word arrives one edge after its address is presented. The destination index starts at zero and rises by one per store. A one-cycle done pulse follows the final store. A start that arrives while a merge is running has no effect. After the done pulse the unit waits for the next start.

Top module: `merge_engine`

## Requirements
- R1: After reset, done_o and out_we_o are low and no read or write activity is pending until start_i is seen high.
- R2: For ascending unsigned inputs, the sequence of written words is the ascending merge of source A's first len_a words and source B's first len_b words.
- R3: Write indices begin at 0 and rise by exactly one per write, with exactly len_a+len_b writes per merge.
- R4: If start_i is sampled high in cycle S, write number k (counting from 0) occurs in cycle S+2+k, with no idle cycle between writes.
- R5: done_o is high for exactly one cycle, at cycle S+len_a+len_b+2. No write happens in that cycle.
- R6: When the two heads are equal, the word from source A is stored first. In that cycle a_raddr_o advances by one and b_raddr_o holds.
- R7: Once one source is exhausted, the remaining words of the other source are written one per cycle in their stored order.
- R8: With len_a = len_b = 0, no write occurs and done_o pulses at cycle S+2.
- R9: A start_i pulse while a merge is in progress is ignored. The lengths, results and timing of the running merge are unchanged.
- R10: Reads are synchronous. In cycle S+1 both read addresses are 0, so the first heads are available in cycle S+2.
- R11: Merging A={1,3,5,7,9} with B={2,4,6,8,10} writes 1 through 10 in order. The last write falls in cycle S+11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a merge when idle |
| len_a_i | input | 9 | Number of words in source A (0..256) |
| len_b_i | input | 9 | Number of words in source B (0..256) |
| a_raddr_o | output | 8 | Read address for source A memory |
| a_rdata_i | input | 16 | Registered read data from source A |
| b_raddr_o | output | 8 | Read address for source B memory |
| b_rdata_i | input | 16 | Registered read data from source B |
| out_we_o | output | 1 | Destination write enable |
| out_waddr_o | output | 9 | Destination write index |
| out_wdata_o | output | 16 | Destination write data |
| done_o | output | 1 | One-cycle pulse after the last write |

## Verification
Two events can fall in the same cycle: the store of one source's last word, and the start of copy-through from the other source. The bench provokes this with lists of unequal length and with random lists that have many duplicate values, so exhaustion, ties and copy-through overlap. Each write is judged against a merge computed in the bench, on its index, its value and the exact cycle in which it lands. A second start arriving mid-merge is also injected, and the running merge must be unaffected.

// File: rtl/merge_pkg.sv
package merge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRIME = 2'd1,
    ST_RUN   = 2'd2
  } merge_state_e;
endpackage

// File: rtl/merge_src.sv
// Per-source read pointer. raddr_o is the index the head will hold next cycle.
module merge_src #(
  parameter int LW = 9,
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          take_i,
  input  logic [LW-1:0] len_i,
  output logic          valid_o,
  output logic [AW-1:0] raddr_o
);
  logic [LW-1:0] idx_q, idx_d;

  always_comb begin
    if (clear_i)     idx_d = '0;
    else if (take_i) idx_d = idx_q + 1'b1;
    else             idx_d = idx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else         idx_q <= idx_d;
  end

  assign valid_o = (idx_q < len_i);
  assign raddr_o = idx_d[AW-1:0];
endmodule

// File: rtl/merge_pick.sv
// Head compare; ties favour source A.
module merge_pick #(
  parameter int DW = 16
) (
  input  logic          run_i,
  input  logic          a_valid_i,
  input  logic          b_valid_i,
  input  logic [DW-1:0] a_head_i,
  input  logic [DW-1:0] b_head_i,
  output logic          take_a_o,
  output logic          take_b_o,
  output logic          we_o,
  output logic [DW-1:0] wdata_o
);
  logic pick_a;

  assign pick_a   = a_valid_i && (!b_valid_i || (a_head_i <= b_head_i));
  assign take_a_o = run_i && pick_a;
  assign take_b_o = run_i && b_valid_i && !pick_a;
  assign we_o     = take_a_o || take_b_o;
  assign wdata_o  = pick_a ? a_head_i : b_head_i;
endmodule

// File: rtl/merge_sink.sv
// Destination index counter and done pulse.
module merge_sink #(
  parameter int TW  = 10,
  parameter int OAW = 9
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           we_i,
  input  logic           empty_i,
  input  logic [TW-1:0]  total_i,
  output logic [OAW-1:0] waddr_o,
  output logic           last_o,
  output logic           done_o
);
  logic [TW-1:0] cnt_q;

  assign last_o  = we_i && ((cnt_q + 1'b1) == total_i);
  assign waddr_o = cnt_q[OAW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      if (clear_i)   cnt_q <= '0;
      else if (we_i) cnt_q <= cnt_q + 1'b1;
      done_o <= last_o || empty_i;
    end
  end
endmodule

// File: rtl/merge_engine.sv
module merge_engine
  import merge_pkg::*;
#(
  parameter int MAX_LEN = 256,
  parameter int DW      = 16,
  localparam int LW     = $clog2(MAX_LEN + 1),
  localparam int AW     = $clog2(MAX_LEN),
  localparam int OAW    = $clog2(2 * MAX_LEN),
  localparam int TW     = OAW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [LW-1:0]  len_a_i,
  input  logic [LW-1:0]  len_b_i,
  output logic [AW-1:0]  a_raddr_o,
  input  logic [DW-1:0]  a_rdata_i,
  output logic [AW-1:0]  b_raddr_o,
  input  logic [DW-1:0]  b_rdata_i,
  output logic           out_we_o,
  output logic [OAW-1:0] out_waddr_o,
  output logic [DW-1:0]  out_wdata_o,
  output logic           done_o
);
  merge_state_e  state_q, state_d;
  logic [LW-1:0] len_q [2];
  logic [TW-1:0] total;
  logic          clear, run, empty, last;
  logic          valid [2];
  logic          take  [2];
  logic [AW-1:0] raddr [2];

  assign clear = (state_q == ST_IDLE) && start_i;
  assign run   = (state_q == ST_RUN);
  assign total = TW'(len_q[0]) + TW'(len_q[1]);
  assign empty = (state_q == ST_PRIME) && (total == '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_PRIME;
      ST_PRIME: state_d = empty ? ST_IDLE : ST_RUN;
      ST_RUN:   if (last) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      len_q[0] <= '0;
      len_q[1] <= '0;
    end else begin
      state_q <= state_d;
      if (clear) begin
        len_q[0] <= len_a_i;
        len_q[1] <= len_b_i;
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_src
    merge_src #(.LW(LW), .AW(AW)) u_src (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear),
      .take_i  (take[g]),
      .len_i   (len_q[g]),
      .valid_o (valid[g]),
      .raddr_o (raddr[g])
    );
  end

  assign a_raddr_o = raddr[0];
  assign b_raddr_o = raddr[1];

  merge_pick #(.DW(DW)) u_pick (
    .run_i     (run),
    .a_valid_i (valid[0]),
    .b_valid_i (valid[1]),
    .a_head_i  (a_rdata_i),
    .b_head_i  (b_rdata_i),
    .take_a_o  (take[0]),
    .take_b_o  (take[1]),
    .we_o      (out_we_o),
    .wdata_o   (out_wdata_o)
  );

  merge_sink #(.TW(TW), .OAW(OAW)) u_sink (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .we_i    (out_we_o),
    .empty_i (empty),
    .total_i (total),
    .waddr_o (out_waddr_o),
    .last_o  (last),
    .done_o  (done_o)
  );
endmodule

// File: rtl/merge_engine_chk.sv
module merge_engine_chk
  import merge_pkg::*;
#(
  parameter int DW  = 16,
  parameter int OAW = 9
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           out_we_i,
  input logic [OAW-1:0] out_waddr_i,
  input logic [DW-1:0]  out_wdata_i,
  input logic           done_i,
  input merge_state_e   state_i
);
  assert_waddr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_we_i && $past(out_we_i) |-> out_waddr_i == $past(out_waddr_i) + 1'b1);

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  assert_no_write_at_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !out_we_i);

  assert_ascending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_we_i && $past(out_we_i) |-> out_wdata_i >= $past(out_wdata_i));

  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_IDLE) && start_i |=> state_i != ST_PRIME);
endmodule

bind merge_engine merge_engine_chk #(.DW(DW), .OAW(OAW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .out_we_i    (out_we_o),
  .out_waddr_i (out_waddr_o),
  .out_wdata_i (out_wdata_o),
  .done_i      (done_o),
  .state_i     (state_q)
);

// File: tb/tb_merge_engine.sv
module tb_merge_engine;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_LEN    = 256;
  localparam int DW         = 16;
  localparam int LW         = 9;
  localparam int AW         = 8;
  localparam int OAW        = 9;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start_i = 1'b0;
  logic [LW-1:0]  len_a_i = '0;
  logic [LW-1:0]  len_b_i = '0;
  logic [AW-1:0]  a_raddr_o, b_raddr_o;
  logic [DW-1:0]  a_rdata_i, b_rdata_i;
  logic           out_we_o, done_o;
  logic [OAW-1:0] out_waddr_o;
  logic [DW-1:0]  out_wdata_o;

  logic [DW-1:0] a_mem [MAX_LEN];
  logic [DW-1:0] b_mem [MAX_LEN];
  logic [DW-1:0] exp_q [2*MAX_LEN];

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  merge_engine dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .len_a_i(len_a_i), .len_b_i(len_b_i),
    .a_raddr_o(a_raddr_o), .a_rdata_i(a_rdata_i),
    .b_raddr_o(b_raddr_o), .b_rdata_i(b_rdata_i),
    .out_we_o(out_we_o), .out_waddr_o(out_waddr_o),
    .out_wdata_o(out_wdata_o), .done_o(done_o)
  );

  always_ff @(posedge clk_i) begin
    a_rdata_i <= a_mem[a_raddr_o];
    b_rdata_i <= b_mem[b_raddr_o];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic fill(input int la, input int lb, input int step);
    int v;
    v = int'($urandom_range(0, 20));
    for (int i = 0; i < la; i++) begin
      a_mem[i] = DW'(v);
      v += int'($urandom_range(0, step));
    end
    v = int'($urandom_range(0, 20));
    for (int i = 0; i < lb; i++) begin
      b_mem[i] = DW'(v);
      v += int'($urandom_range(0, step));
    end
  endtask

  task automatic build_exp(input int la, input int lb);
    int ia = 0, ib = 0;
    for (int k = 0; k < la + lb; k++) begin
      if (ia < la && (ib >= lb || a_mem[ia] <= b_mem[ib])) begin
        exp_q[k] = a_mem[ia]; ia++;
      end else begin
        exp_q[k] = b_mem[ib]; ib++;
      end
    end
  endtask

  task automatic run(input int la, input int lb, input bit tie_chk,
                     input bit inject, input string dreq);
    int  total = la + lb;
    int  wc = 0;
    bit  seen = 1'b0;
    build_exp(la, lb);
    @(negedge clk_i);
    start_i = 1'b1; len_a_i = LW'(la); len_b_i = LW'(lb);
    for (int cyc = 1; cyc <= 1200 && !seen; cyc++) begin
      @(negedge clk_i);
      if (cyc == 1) begin
        chk(a_raddr_o == 0, "R10", "a_raddr in prime cycle", int'(a_raddr_o), 0);
        chk(b_raddr_o == 0, "R10", "b_raddr in prime cycle", int'(b_raddr_o), 0);
      end
      if (tie_chk && cyc == 2) begin
        chk(a_raddr_o == 1, "R6", "a_raddr after tie", int'(a_raddr_o), 1);
        chk(b_raddr_o == 0, "R6", "b_raddr after tie", int'(b_raddr_o), 0);
      end
      if (out_we_o) begin
        chk(int'(out_waddr_o) == wc, "R3", "write index", int'(out_waddr_o), wc);
        chk(out_wdata_o == exp_q[wc], dreq, "write data", int'(out_wdata_o), int'(exp_q[wc]));
        chk(cyc == wc + 2, "R4", "write cycle", cyc, wc + 2);
        wc++;
      end
      if (done_o) begin
        seen = 1'b1;
        chk(cyc == total + 2, (total == 0) ? "R8" : "R5", "done cycle", cyc, total + 2);
        chk(!out_we_o, "R5", "write during done", int'(out_we_o), 0);
        chk(wc == total, "R3", "write count", wc, total);
      end else begin
        start_i = inject && (cyc == 3);
        if (inject && cyc == 3) begin
          len_a_i = LW'(3); len_b_i = LW'(1);  // R9 stray start
        end
      end
    end
    start_i = 1'b0;
    if (!seen) chk(1'b0, "R5", "done never seen", 0, 1);
    @(negedge clk_i);
    chk(!done_o, "R5", "done width", int'(done_o), 0);
    chk(!out_we_o, (total == 0) ? "R8" : "R9", "write after done", int'(out_we_o), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!done_o, "R1", "done after reset", int'(done_o), 0);
    chk(!out_we_o, "R1", "we after reset", int'(out_we_o), 0);

    // R11 interleaved example
    for (int i = 0; i < 5; i++) begin
      a_mem[i] = DW'(2*i + 1);
      b_mem[i] = DW'(2*i + 2);
    end
    run(5, 5, 1'b0, 1'b0, "R11");

    // R6 equal heads
    a_mem[0] = 16'd5; b_mem[0] = 16'd5;
    run(1, 1, 1'b1, 1'b0, "R6");

    // R8 both empty, R7 one side empty
    run(0, 0, 1'b0, 1'b0, "R8");
    fill(0, 7, 3);
    run(0, 7, 1'b0, 1'b0, "R7");
    fill(6, 0, 3);
    run(6, 0, 1'b0, 1'b0, "R7");

    // R7 A exhausted early, B copied through
    for (int i = 0; i < 3; i++) a_mem[i] = DW'(i);
    for (int i = 0; i < 9; i++) b_mem[i] = DW'(10 + i);
    run(3, 9, 1'b0, 1'b0, "R7");

    // R9 start while busy
    fill(12, 10, 4);
    run(12, 10, 1'b0, 1'b1, "R9");

    // full length on both sides
    fill(MAX_LEN, MAX_LEN, 2);
    run(MAX_LEN, MAX_LEN, 1'b0, 1'b0, "R2");

    // random lists, many duplicates
    for (int t = 0; t < 25; t++) begin
      int la = int'($urandom_range(0, 40));
      int lb = int'($urandom_range(0, 40));
      fill(la, lb, (t % 3 == 0) ? 0 : 3);
      run(la, lb, 1'b0, (la + lb >= 6) && (t % 4 == 1), "R2");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule